// File: doc/BRIEF.md
# Dual-Format Subroutine Call Sequencer

This block runs the call, jump and return sequences of a small 4-bit controller core. The decoder hands it one instruction class at a time, together with a destination, the return address and two status bits. For a call, the sequencer pushes a frame onto a byte-wide stack held in external synchronous RAM. For a return, it pops that frame back and delivers the restored program counter. Each operation holds a busy flag high for its whole cycle count. The new program counter is presented only in the final cycle.

One bit of a 4-bit select register picks between two frame formats. The narrow format stores a 14-bit return address and the status bits in two bytes, which limits programs to a 16 Kbyte space. The wide format adds a third byte with the upper return-address bits. Switching to the wide format adds one cycle to the absolute and short calls. It also unlocks the long call and long jump forms, which are rejected in the narrow format.

Top module: `scs_call_seq`

## Requirements
- R1: After synchronous reset, `sp` is 0, `busy`, `illegal`, `pc_new_valid`, `stk_we` and `stk_re` are low, and `sel_reg` is 0 (narrow format).
- R2: `instr_class` encodes 0 none, 1 absolute call, 2 short call, 3 long call, 4 long jump, 5 return. Codes 6 and 7 act as none. A class is taken only when `instr_valid` is high and `busy` is low. `busy` rises in the cycle after that edge.
- R3: Bit 3 of `sel_reg` selects the format: 0 narrow, 1 wide. A write while idle lands at that edge. An instruction taken at that same edge still runs in the previous format.
- R4: A narrow call pushes two bytes, one per cycle, starting with its first busy cycle. The stack pointer is decremented before each write, so from `sp`=0 the bytes go to 0xFF, then 0xFE. The first byte is return[7:0]; the second is {flags[1:0], return[13:8]}.
- R5: A wide call pushes three bytes. The first two are as in R4, and the third is return[15:14] in its low bits with zeros above.
- R6: An absolute call keeps `busy` high for 3 cycles in the narrow format and 4 in the wide one. Its destination is target[13:0] with the upper bits zero.
- R7: A short call keeps `busy` high for 2 cycles in the narrow format and 3 in the wide one. Its destination is target[10:0] zero-extended.
- R8: In the wide format, a long call takes 3 cycles, pushes a three-byte frame and jumps to the full 16-bit target. A long jump takes 2 cycles, touches no stack and jumps to the full target.
- R9: In the narrow format, a long call or long jump raises `illegal` for exactly one cycle. `busy` stays low, and the stack strobes, `sp` and `pc_new_valid` are unaffected.
- R10: A return pops the frame size of the format current when it is taken. Each pop reads at `sp` and then increments. It lasts frame size plus 2 cycles. The final cycle shows the rebuilt address (upper bits zero in the narrow format) and the saved flags on `ret_flags`.
- R11: A select write that arrives while `busy` is high leaves `sel_reg` unchanged until the instruction's last cycle has ended.
- R12: `pc_new_valid` is high in exactly one cycle per taken operation, the last cycle of `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Decoded instruction present |
| instr_class | input | 3 | Instruction class code |
| target | input | 16 | Destination field of the instruction |
| pc_in | input | 16 | Return address to save on a call |
| flags_in | input | 2 | Status bits saved with the frame |
| sel_wr_en | input | 1 | Select register write strobe |
| sel_wr_data | input | 4 | Select register write value |
| sel_reg | output | 4 | Current select register contents |
| stk_we | output | 1 | Stack RAM write strobe |
| stk_re | output | 1 | Stack RAM read strobe, data next cycle |
| stk_addr | output | 8 | Stack RAM address |
| stk_wdata | output | 8 | Stack RAM write byte |
| stk_rdata | input | 8 | Stack RAM read byte |
| sp | output | 8 | Stack pointer |
| pc_new | output | 16 | New program counter, valid with pc_new_valid |
| pc_new_valid | output | 1 | Last cycle of an operation |
| ret_flags | output | 2 | Status bits restored by a return |
| busy | output | 1 | Operation in progress |
| illegal | output | 1 | Disallowed opcode seen |

## Verification
A select-register write can land on the same edge as an instruction being taken. It can also land inside a running call, so that the deferred update meets the completion edge. The bench drives the write and the instruction valid in the same idle cycle, and expects a narrow-length call with a two-byte frame even though `sel_reg` reads wide afterwards. It also writes during the second cycle of a wide call, and expects `sel_reg` to hold through the remaining busy cycles and change only once `busy` falls. A following return then pops two bytes under the new format.

// File: rtl/scs_pkg.sv
package scs_pkg;
  localparam int BYTE_W = 8;
  localparam int CLS_W  = 3;
  localparam int CNT_W  = 3;

  typedef enum logic [CLS_W-1:0] {
    OP_NONE  = 3'd0,
    OP_CALL  = 3'd1,
    OP_CALLF = 3'd2,
    OP_CALLL = 3'd3,
    OP_BRL   = 3'd4,
    OP_RET   = 3'd5
  } op_e;

  function automatic logic [CNT_W-1:0] frame_bytes(input logic wide);
    frame_bytes = wide ? 3'd3 : 3'd2;
  endfunction

  function automatic logic [CNT_W-1:0] op_cycles(input op_e op, input logic wide);
    case (op)
      OP_CALL:  op_cycles = wide ? 3'd4 : 3'd3;
      OP_CALLF: op_cycles = wide ? 3'd3 : 3'd2;
      OP_CALLL: op_cycles = 3'd3;
      OP_BRL:   op_cycles = 3'd2;
      OP_RET:   op_cycles = frame_bytes(wide) + 3'd2;
      default:  op_cycles = 3'd1;
    endcase
  endfunction

  function automatic logic is_call(input op_e op);
    is_call = (op == OP_CALL) || (op == OP_CALLF) || (op == OP_CALLL);
  endfunction

  function automatic logic op_allowed(input op_e op, input logic wide);
    op_allowed = wide || !((op == OP_CALLL) || (op == OP_BRL));
  endfunction

  function automatic op_e decode_class(input logic [CLS_W-1:0] c);
    case (c)
      3'd1:    decode_class = OP_CALL;
      3'd2:    decode_class = OP_CALLF;
      3'd3:    decode_class = OP_CALLL;
      3'd4:    decode_class = OP_BRL;
      3'd5:    decode_class = OP_RET;
      default: decode_class = OP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/scs_mode_reg.sv
module scs_mode_reg #(
  parameter int SBS_W    = 4,
  parameter int MODE_BIT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SBS_W-1:0] wr_data,
  input  logic             busy_i,
  input  logic             done_i,
  output logic [SBS_W-1:0] sbs_o,
  output logic             wide_o
);
  logic [SBS_W-1:0] sbs_q;
  logic [SBS_W-1:0] pend_q;
  logic             pend_v;

  // Writes during an operation are parked and applied at its final edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      sbs_q  <= '0;
      pend_q <= '0;
      pend_v <= 1'b0;
    end else if (busy_i && !done_i) begin
      if (wr_en) begin
        pend_q <= wr_data;
        pend_v <= 1'b1;
      end
    end else begin
      if (wr_en)       sbs_q <= wr_data;
      else if (pend_v) sbs_q <= pend_q;
      pend_v <= 1'b0;
    end
  end

  assign sbs_o  = sbs_q;
  assign wide_o = sbs_q[MODE_BIT];

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy_i && !done_i) |=> $stable(sbs_q)); // R11
  AST_NO_STALE_PEND: assert property (@(posedge clk) disable iff (rst)
    !busy_i |-> !pend_v); // R11
endmodule

// File: rtl/scs_frame.sv
module scs_frame #(
  parameter int PC_W  = 16,
  parameter int FLG_W = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wide_i,
  input  logic [PC_W-1:0]           ret_addr,
  input  logic [FLG_W-1:0]          flags,
  input  logic [scs_pkg::CNT_W-1:0] push_idx,
  input  logic                      cap_en,
  input  logic [1:0]                cap_pos,
  input  logic [scs_pkg::BYTE_W-1:0] rdata,
  output logic [scs_pkg::BYTE_W-1:0] push_byte,
  output logic [PC_W-1:0]           pop_ret,
  output logic [FLG_W-1:0]          pop_flags
);
  localparam int BW    = scs_pkg::BYTE_W;
  localparam int LEG_W = 2*BW - FLG_W;
  localparam int MID_W = LEG_W - BW;
  localparam int UP_W  = PC_W - LEG_W;

  logic [BW-1:0]   lo_q;
  logic [BW-1:0]   mid_q;
  logic [UP_W-1:0] up_q;

  // Byte 0: low address, byte 1: flags and middle bits, byte 2: upper bits.
  always_comb begin
    case (push_idx)
      3'd0:    push_byte = ret_addr[BW-1:0];
      3'd1:    push_byte = {flags, ret_addr[LEG_W-1:BW]};
      default: push_byte = {{(BW-UP_W){1'b0}}, ret_addr[PC_W-1:LEG_W]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q  <= '0;
      mid_q <= '0;
      up_q  <= '0;
    end else if (cap_en) begin
      case (cap_pos)
        2'd0:    lo_q  <= rdata;
        2'd1:    mid_q <= rdata;
        2'd2:    up_q  <= rdata[UP_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    if (wide_i) pop_ret = {up_q, mid_q[MID_W-1:0], lo_q};
    else        pop_ret = {{UP_W{1'b0}}, mid_q[MID_W-1:0], lo_q};
    pop_flags = mid_q[BW-1 -: FLG_W];
  end
endmodule

// File: rtl/scs_ctrl.sv
module scs_ctrl
  import scs_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int SP_W    = 8,
  parameter int SHORT_W = 11,
  parameter int FLG_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instr_valid,
  input  op_e              op_in,
  input  logic [PC_W-1:0]  target,
  input  logic [PC_W-1:0]  pc_in,
  input  logic [FLG_W-1:0] flags_in,
  input  logic             wide_i,
  output logic             busy_o,
  output logic             last_o,
  output logic             illegal_o,
  output logic             push_o,
  output logic             pop_o,
  output logic [SP_W-1:0]  addr_o,
  output logic [SP_W-1:0]  sp_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             cap_en_o,
  output logic [1:0]       cap_pos_o,
  output logic             wide_q_o,
  output op_e              op_q_o,
  output logic [PC_W-1:0]  tgt_o,
  output logic [PC_W-1:0]  ret_o,
  output logic [FLG_W-1:0] flags_o
);
  localparam int LEG_W = 2*BYTE_W - FLG_W;

  logic             busy_q, illegal_q, wide_q;
  op_e              op_q;
  logic [CNT_W-1:0] cnt_q, ncyc_q, fb_q;
  logic [SP_W-1:0]  sp_q;
  logic [PC_W-1:0]  tgt_q, ret_q, tgt_map;
  logic [FLG_W-1:0] flags_q;
  logic             take, bad, last, push, pop;

  always_comb begin
    case (op_in)
      OP_CALL:  tgt_map = PC_W'(target[LEG_W-1:0]);
      OP_CALLF: tgt_map = PC_W'(target[SHORT_W-1:0]);
      default:  tgt_map = target;
    endcase
  end

  assign take = instr_valid && !busy_q && (op_in != OP_NONE);
  assign bad  = take && !op_allowed(op_in, wide_i);
  assign last = busy_q && (cnt_q == ncyc_q - 3'd1);
  assign push = busy_q && is_call(op_q) && (cnt_q < fb_q);
  assign pop  = busy_q && (op_q == OP_RET) && (cnt_q < fb_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      illegal_q <= 1'b0;
      wide_q    <= 1'b0;
      op_q      <= OP_NONE;
      cnt_q     <= '0;
      ncyc_q    <= '0;
      fb_q      <= '0;
      tgt_q     <= '0;
      ret_q     <= '0;
      flags_q   <= '0;
    end else begin
      illegal_q <= bad;
      if (take && !bad) begin
        busy_q  <= 1'b1;
        cnt_q   <= '0;
        op_q    <= op_in;
        wide_q  <= wide_i;
        ncyc_q  <= op_cycles(op_in, wide_i);
        fb_q    <= frame_bytes(wide_i);
        tgt_q   <= tgt_map;
        ret_q   <= pc_in;
        flags_q <= flags_in;
      end else if (busy_q) begin
        if (last) busy_q <= 1'b0;
        cnt_q <= cnt_q + 3'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       sp_q <= '0;
    else if (push) sp_q <= sp_q - 1'b1;
    else if (pop)  sp_q <= sp_q + 1'b1;
  end

  assign busy_o    = busy_q;
  assign last_o    = last;
  assign illegal_o = illegal_q;
  assign push_o    = push;
  assign pop_o     = pop;
  assign addr_o    = push ? (sp_q - 1'b1) : sp_q;
  assign sp_o      = sp_q;
  assign cnt_o     = cnt_q;
  assign cap_en_o  = busy_q && (op_q == OP_RET) && (cnt_q != 3'd0) && (cnt_q <= fb_q);
  assign cap_pos_o = 2'(fb_q - cnt_q);
  assign wide_q_o  = wide_q;
  assign op_q_o    = op_q;
  assign tgt_o     = tgt_q;
  assign ret_o     = ret_q;
  assign flags_o   = flags_q;

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
    illegal_q |-> (!busy_q && !push && !pop)); // R9
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
    last |=> !busy_q); // R12
  AST_SP_PUSH: assert property (@(posedge clk) disable iff (rst)
    push |=> (sp_q == $past(sp_q) - 1'b1)); // R4
  AST_SP_POP: assert property (@(posedge clk) disable iff (rst)
    pop |=> (sp_q == $past(sp_q) + 1'b1)); // R10
endmodule

// File: rtl/scs_call_seq.sv
module scs_call_seq
  import scs_pkg::*;
#(
  parameter int PC_W     = 16,
  parameter int SP_W     = 8,
  parameter int SBS_W    = 4,
  parameter int MODE_BIT = 3,
  parameter int SHORT_W  = 11,
  parameter int FLG_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [CLS_W-1:0]  instr_class,
  input  logic [PC_W-1:0]   target,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [FLG_W-1:0]  flags_in,
  input  logic              sel_wr_en,
  input  logic [SBS_W-1:0]  sel_wr_data,
  output logic [SBS_W-1:0]  sel_reg,
  output logic              stk_we,
  output logic              stk_re,
  output logic [SP_W-1:0]   stk_addr,
  output logic [BYTE_W-1:0] stk_wdata,
  input  logic [BYTE_W-1:0] stk_rdata,
  output logic [SP_W-1:0]   sp,
  output logic [PC_W-1:0]   pc_new,
  output logic              pc_new_valid,
  output logic [FLG_W-1:0]  ret_flags,
  output logic              busy,
  output logic              illegal
);
  op_e              op_in, op_q;
  logic             wide_cur, wide_q, last, cap_en;
  logic [1:0]       cap_pos;
  logic [CNT_W-1:0] cnt;
  logic [PC_W-1:0]  tgt_q, ret_q, pop_ret;
  logic [FLG_W-1:0] flags_q;

  assign op_in = decode_class(instr_class);

  scs_mode_reg #(.SBS_W(SBS_W), .MODE_BIT(MODE_BIT)) u_mode (
    .clk(clk), .rst(rst), .wr_en(sel_wr_en), .wr_data(sel_wr_data),
    .busy_i(busy), .done_i(last), .sbs_o(sel_reg), .wide_o(wide_cur)
  );

  scs_ctrl #(.PC_W(PC_W), .SP_W(SP_W), .SHORT_W(SHORT_W), .FLG_W(FLG_W)) u_ctrl (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .op_in(op_in),
    .target(target), .pc_in(pc_in), .flags_in(flags_in), .wide_i(wide_cur),
    .busy_o(busy), .last_o(last), .illegal_o(illegal), .push_o(stk_we),
    .pop_o(stk_re), .addr_o(stk_addr), .sp_o(sp), .cnt_o(cnt),
    .cap_en_o(cap_en), .cap_pos_o(cap_pos), .wide_q_o(wide_q), .op_q_o(op_q),
    .tgt_o(tgt_q), .ret_o(ret_q), .flags_o(flags_q)
  );

  scs_frame #(.PC_W(PC_W), .FLG_W(FLG_W)) u_frame (
    .clk(clk), .rst(rst), .wide_i(wide_q), .ret_addr(ret_q), .flags(flags_q),
    .push_idx(cnt), .cap_en(cap_en), .cap_pos(cap_pos), .rdata(stk_rdata),
    .push_byte(stk_wdata), .pop_ret(pop_ret), .pop_flags(ret_flags)
  );

  assign pc_new       = (op_q == OP_RET) ? pop_ret : tgt_q;
  assign pc_new_valid = last;
endmodule

// File: tb/tb_scs_call_seq.sv
`timescale 1ns/1ps
module tb_scs_call_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [2:0]  instr_class = '0;
  logic [15:0] target = '0, pc_in = '0;
  logic [1:0]  flags_in = '0;
  logic        sel_wr_en = 1'b0;
  logic [3:0]  sel_wr_data = '0;
  logic [3:0]  sel_reg;
  logic        stk_we, stk_re, pc_new_valid, busy, illegal;
  logic [7:0]  stk_addr, stk_wdata, sp;
  logic [7:0]  stk_rdata = '0;
  logic [15:0] pc_new;
  logic [1:0]  ret_flags;

  always #10 clk = ~clk;

  scs_call_seq dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_class(instr_class),
    .target(target), .pc_in(pc_in), .flags_in(flags_in), .sel_wr_en(sel_wr_en),
    .sel_wr_data(sel_wr_data), .sel_reg(sel_reg), .stk_we(stk_we), .stk_re(stk_re),
    .stk_addr(stk_addr), .stk_wdata(stk_wdata), .stk_rdata(stk_rdata), .sp(sp),
    .pc_new(pc_new), .pc_new_valid(pc_new_valid), .ret_flags(ret_flags),
    .busy(busy), .illegal(illegal)
  );

  logic [7:0] mem [0:255];
  always @(posedge clk) begin
    if (stk_we) mem[stk_addr] <= stk_wdata;
    if (stk_re) stk_rdata <= mem[stk_addr];
  end

  int n_tot = 0, n_fail = 0;
  int cyc, nw, nr, pcv_n, pcv_at, ill_n;
  logic [7:0]  waddr [0:3];
  logic [7:0]  wdat  [0:3];
  logic [7:0]  raddr [0:3];
  logic [7:0]  sp0;
  logic [15:0] pc_seen;
  logic [1:0]  fl_seen;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge where busy is low again.
  task automatic exec(input logic [2:0] c, input logic [15:0] t, input logic [15:0] p,
                      input logic [1:0] f);
    cyc = 0; nw = 0; nr = 0; pcv_n = 0; pcv_at = 0; ill_n = 0; sp0 = sp;
    instr_valid = 1'b1; instr_class = c; target = t; pc_in = p; flags_in = f;
    @(negedge clk);
    instr_valid = 1'b0; sel_wr_en = 1'b0;
    for (int k = 0; k < 12; k++) begin
      if (illegal) ill_n++;
      if (!busy) break;
      cyc++;
      if (stk_we && nw < 4) begin waddr[nw] = stk_addr; wdat[nw] = stk_wdata; nw++; end
      if (stk_re && nr < 4) begin raddr[nr] = stk_addr; nr++; end
      if (pc_new_valid) begin pcv_n++; pcv_at = cyc; pc_seen = pc_new; fl_seen = ret_flags; end
      @(negedge clk);
    end
  endtask

  task automatic set_mode(input logic [3:0] v);
    sel_wr_en = 1'b1; sel_wr_data = v;
    @(negedge clk);
    sel_wr_en = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 sp", sp, 0); check("R1 busy", busy, 0); check("R1 illegal", illegal, 0);
    check("R1 sel_reg", sel_reg, 0); check("R1 strobes", {stk_we, stk_re, pc_new_valid}, 0);
    exec(3'd6, 16'h1234, 16'h0000, 2'b00);
    check("R2 class6 ignored", cyc, 0);
    exec(3'd0, 16'h1234, 16'h0000, 2'b00);
    check("R2 class0 ignored", cyc, 0);
    check("R2 sp unchanged", sp, 0);
  endtask

  task automatic t_narrow_call_ret();
    exec(3'd1, 16'h7ABC, 16'hC123, 2'b10);
    check("R6 narrow call cycles", cyc, 3);
    check("R4 bytes", nw, 2);
    check("R4 addr0", waddr[0], 8'hFF); check("R4 addr1", waddr[1], 8'hFE);
    check("R4 byte0", wdat[0], 8'h23); check("R4 byte1", wdat[1], 8'h81);
    check("R12 pc once", pcv_n, 1); check("R12 pc last", pcv_at, 3);
    check("R6 target", pc_seen, 16'h3ABC);
    check("R4 sp", sp, 8'hFE);
    exec(3'd5, 16'h0, 16'h0, 2'b00);
    check("R10 narrow ret cycles", cyc, 4);
    check("R10 pops", nr, 2);
    check("R10 raddr0", raddr[0], 8'hFE); check("R10 raddr1", raddr[1], 8'hFF);
    check("R10 ret pc", pc_seen, 16'h0123); check("R10 flags", fl_seen, 2'b10);
    check("R12 ret pc last", pcv_at, 4);
    check("R10 sp", sp, 8'h00);
  endtask

  task automatic t_narrow_short();
    exec(3'd2, 16'hFFFF, 16'h1234, 2'b00);
    check("R7 narrow short cycles", cyc, 2);
    check("R7 target", pc_seen, 16'h07FF);
    check("R4 short bytes", nw, 2);
    exec(3'd5, 16'h0, 16'h0, 2'b00);
    check("R10 short ret pc", pc_seen, 16'h1234);
    check("R10 sp back", sp, 8'h00);
  endtask

  task automatic t_illegal(input logic [2:0] c);
    exec(c, 16'hC00F, 16'h1111, 2'b01);
    check("R9 illegal pulse", ill_n, 1);
    check("R9 no busy", cyc, 0);
    check("R9 no pc", pcv_n, 0);
    check("R9 no writes", nw, 0);
    check("R9 sp kept", sp, sp0);
    @(negedge clk);
    check("R9 one cycle", illegal, 0);
  endtask

  task automatic t_wide_call_ret();
    set_mode(4'b1000);
    check("R3 sel_reg wide", sel_reg, 4'b1000);
    exec(3'd1, 16'hFABC, 16'hC123, 2'b01);
    check("R6 wide call cycles", cyc, 4);
    check("R5 bytes", nw, 3);
    check("R5 addr2", waddr[2], 8'hFD);
    check("R5 byte0", wdat[0], 8'h23); check("R5 byte1", wdat[1], 8'h41);
    check("R5 byte2", wdat[2], 8'h03);
    check("R6 wide target", pc_seen, 16'h3ABC);
    check("R12 wide call last", pcv_at, 4);
    exec(3'd5, 16'h0, 16'h0, 2'b00);
    check("R10 wide ret cycles", cyc, 5);
    check("R10 wide pops", nr, 3);
    check("R10 wide raddr0", raddr[0], 8'hFD);
    check("R10 wide ret pc", pc_seen, 16'hC123);
    check("R10 wide flags", fl_seen, 2'b01);
    check("R10 wide sp", sp, 8'h00);
  endtask

  task automatic t_wide_short();
    exec(3'd2, 16'hFFFF, 16'h4321, 2'b11);
    check("R7 wide short cycles", cyc, 3);
    check("R7 wide short bytes", nw, 3);
    check("R7 wide short target", pc_seen, 16'h07FF);
    exec(3'd5, 16'h0, 16'h0, 2'b00);
    check("R10 wide short ret", pc_seen, 16'h4321);
  endtask

  task automatic t_long();
    exec(3'd3, 16'hC00F, 16'h8001, 2'b00);
    check("R8 long call cycles", cyc, 3);
    check("R8 long call bytes", nw, 3);
    check("R8 long call target", pc_seen, 16'hC00F);
    check("R8 no illegal", ill_n, 0);
    exec(3'd5, 16'h0, 16'h0, 2'b00);
    check("R8 long ret", pc_seen, 16'h8001);
    exec(3'd4, 16'h9ABC, 16'h0000, 2'b00);
    check("R8 long jump cycles", cyc, 2);
    check("R8 long jump no stack", nw + nr, 0);
    check("R8 long jump target", pc_seen, 16'h9ABC);
    check("R8 long jump sp", sp, sp0);
  endtask

  task automatic t_defer();
    sp0 = sp;
    instr_valid = 1'b1; instr_class = 3'd1; target = 16'h0100; pc_in = 16'h4567; flags_in = 2'b00;
    @(negedge clk);
    instr_valid = 1'b0;
    sel_wr_en = 1'b1; sel_wr_data = 4'b0000;
    @(negedge clk);
    sel_wr_en = 1'b0;
    check("R11 held c2", sel_reg, 4'b1000);
    @(negedge clk);
    check("R11 held c3", sel_reg, 4'b1000);
    check("R11 busy c3", busy, 1);
    @(negedge clk);
    check("R11 held last", sel_reg, 4'b1000);
    @(negedge clk);
    check("R11 call done", busy, 0);
    check("R11 applied", sel_reg, 4'b0000);
    exec(3'd5, 16'h0, 16'h0, 2'b00);
    check("R10 current format pops", nr, 2);
    check("R10 current format cycles", cyc, 4);
    check("R10 narrow rebuild", pc_seen, 16'h0105);
  endtask

  task automatic t_same_edge();
    sel_wr_en = 1'b1; sel_wr_data = 4'b1000;
    exec(3'd1, 16'h0042, 16'h0777, 2'b00);
    check("R3 old format cycles", cyc, 3);
    check("R3 old format bytes", nw, 2);
    check("R3 new value", sel_reg, 4'b1000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_narrow_call_ret();
    t_narrow_short();
    t_illegal(3'd3);
    t_illegal(3'd4);
    t_wide_call_ret();
    t_wide_short();
    t_long();
    t_defer();
    t_same_edge();
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tot++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end
endmodule